// File: doc/BRIEF.md
# Spike-Timing Weight Updater

This block applies spike-timing-dependent plasticity to the synaptic weights of one layer of spiking neurons. Once per time unit, the neuron layer hands it the set of inputs that spiked and the set of neurons that spiked in that time unit. The block keeps a saturating age counter per input and per neuron, which counts time units since the last spike. It records which neuron fired first in the current sample and which inputs have spiked at least once. It then walks the whole weight memory, one synapse per clock, and applies a read-modify-write to each weight.

The change applied to a synapse is built from several terms. The first-firing neuron is strengthened from a potentiation table when it fires, and weakened from a depression table when an input spikes after it. Other neurons that fire after a winner exists take a fixed penalty. At the end of a sample, inputs that stayed silent for the whole sample are penalised on every neuron. Each change is capped in magnitude, and the result is held between two programmable limits, so a weight may become negative. Both timing tables hold 30 entries and are set through parameters. Weights are signed 16-bit fixed point with 8 fractional bits.

Top module: `stdp_updater`

## Requirements
- R1: After reset, busy and done are low and every weight reads the parameter W_INIT (default 0).
- R2: A time unit is taken when tu_valid is high and busy is low. busy is high from the next cycle for exactly N_IN*N_NEU cycles. done pulses for one cycle right after busy falls. A tu_valid pulse while busy is ignored and changes no weight and no sample state.
- R3: The winner of a sample is the first neuron to spike in it, with the lowest index taking a tie. When the winner spikes and input i last spiked dt time units earlier (0..29, where 0 means the same time unit), POS_TBL[dt] is added to the weight at address winner*N_IN+i. The weight format is Q8.8.
- R4: When input i spikes dt time units (1..29) after the winner's latest spike, NEG_TBL[dt] is subtracted from the winner's weight for that input.
- R5: A timing difference of 30 or more time units gives no timing-based change.
- R6: The total change to one weight in one time unit is limited to ±DMAX (default 16, i.e. 0.0625).
- R7: Every non-winning neuron that spikes in a time unit in which a winner exists loses LOSE_DEC (default 8) on all of its weights.
- R8: In a time unit flagged sample_last, every input that never spiked during the sample loses SILENT_DEC (default 4) on every neuron. After that sweep the winner, the seen flags and all ages are cleared, so the next sample elects a new winner.
- R9: Every weight written in a sweep, including weights with zero change, is limited to [wmin, wmax]. Weights may be negative.
- R10: With learn_en low when a time unit is taken, no weight changes. The ages, the seen flags and the winner are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_en | input | 1 | Enables weight writes for the time unit being taken |
| wmax | input | 16 | Upper weight limit, signed Q8.8 |
| wmin | input | 16 | Lower weight limit, signed Q8.8 |
| tu_valid | input | 1 | A time unit has completed; spike vectors are valid |
| pre_spk | input | N_IN | Inputs that spiked in this time unit |
| post_spk | input | N_NEU | Neurons that spiked in this time unit |
| sample_last | input | 1 | This time unit closes the current sample |
| busy | output | 1 | Sweep in progress; new time units are refused |
| done | output | 1 | One-cycle pulse when a sweep finishes |
| rd_addr | input | log2(N_IN*N_NEU) | Weight read address, neuron*N_IN+input |
| rd_data | output | 16 | Weight at rd_addr, signed Q8.8 |

## Verification
The bench targets both edges of the timing window. A pre spike exactly 20 and 21 time units before the winner fires gives the small, uncapped table values. A post age of 30 must give nothing, and a design that indexed one past the table end would leak a stray value. Same-time-unit and one-unit differences check that the cap holds large table entries to 16, so an uncapped design would jump by 154 or 63. Tightening the limits mid-run checks that untouched weights are clipped too. A tu_valid injected during a sweep checks that an eager design would not elect a wrong winner or apply a silent penalty. A time unit with learning off, followed by a winner spike, checks that timing state is still tracked while writes are blocked.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  localparam int WW    = 16;                   // weight word, Q8.8
  localparam int TBL_N = 30;                   // timing table depth
  localparam int AW    = $clog2(TBL_N + 1);    // age counter width, holds TBL_N

  typedef logic signed [WW-1:0] wgt_t;
  typedef logic [AW-1:0]        age_t;
  typedef wgt_t                 tbl_t [TBL_N];
endpackage

// File: rtl/stdp_age.sv
module stdp_age
  import stdp_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [N-1:0]     spk,
  output age_t [N-1:0]     age,
  output logic [N-1:0]     seen
);
  localparam age_t MAXA = age_t'(TBL_N);

  for (genvar g = 0; g < N; g++) begin : g_ch
    age_t age_q, age_d;
    logic seen_q, seen_d;

    always_comb begin
      age_d  = age_q;
      seen_d = seen_q;
      if (clear) begin
        age_d  = MAXA;
        seen_d = 1'b0;
      end else if (step) begin
        if (spk[g]) begin
          age_d  = '0;
          seen_d = 1'b1;
        end else if (age_q != MAXA) begin
          age_d  = age_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q  <= MAXA;
        seen_q <= 1'b0;
      end else begin
        age_q  <= age_d;
        seen_q <= seen_d;
      end
    end

    assign age[g]  = age_q;
    assign seen[g] = seen_q;

    // R5
    age_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= MAXA);
    // R3
    age_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !clear && spk[g] |=> age_q == '0);
  end
endmodule

// File: rtl/stdp_delta.sv
module stdp_delta
  import stdp_pkg::*;
#(
  parameter tbl_t POS_TBL    = '{default: '0},
  parameter tbl_t NEG_TBL    = '{default: '0},
  parameter int   DMAX       = 16,
  parameter int   LOSE_DEC   = 8,
  parameter int   SILENT_DEC = 4
) (
  input  logic is_win,
  input  logic pre_now,
  input  logic post_now,
  input  logic loser,
  input  logic silent,
  input  age_t pre_age,
  input  age_t post_age,
  output wgt_t delta
);
  localparam int AccW = WW + 2;
  localparam logic signed [AccW-1:0] HI = AccW'(DMAX);
  localparam logic signed [AccW-1:0] LO = -AccW'(DMAX);

  logic signed [AccW-1:0] acc;

  always_comb begin
    acc = '0;
    if (is_win && post_now && pre_age < age_t'(TBL_N))
      acc = acc + AccW'(POS_TBL[pre_age]);
    if (is_win && pre_now && !post_now && post_age != '0 && post_age < age_t'(TBL_N))
      acc = acc - AccW'(NEG_TBL[post_age]);
    if (loser)
      acc = acc - AccW'(LOSE_DEC);
    if (silent)
      acc = acc - AccW'(SILENT_DEC);
    if (acc > HI)      delta = wgt_t'(HI);
    else if (acc < LO) delta = wgt_t'(LO);
    else               delta = wgt_t'(acc);
  end
endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
  import stdp_pkg::*;
#(
  parameter int   N_IN       = 8,
  parameter int   N_NEU      = 4,
  parameter int   DMAX       = 16,
  parameter int   LOSE_DEC   = 8,
  parameter int   SILENT_DEC = 4,
  parameter int   W_INIT     = 0,
  parameter tbl_t POS_TBL    = '{16'sd154, 16'sd136, 16'sd120, 16'sd106, 16'sd93,
                                 16'sd82,  16'sd73,  16'sd64,  16'sd57,  16'sd50,
                                 16'sd44,  16'sd39,  16'sd34,  16'sd30,  16'sd27,
                                 16'sd24,  16'sd21,  16'sd18,  16'sd16,  16'sd14,
                                 16'sd13,  16'sd11,  16'sd10,  16'sd9,   16'sd8,
                                 16'sd7,   16'sd6,   16'sd5,   16'sd5,   16'sd4},
  parameter tbl_t NEG_TBL    = '{16'sd77,  16'sd63,  16'sd51,  16'sd42,  16'sd35,
                                 16'sd28,  16'sd23,  16'sd19,  16'sd16,  16'sd13,
                                 16'sd10,  16'sd9,   16'sd7,   16'sd6,   16'sd5,
                                 16'sd4,   16'sd3,   16'sd3,   16'sd2,   16'sd2,
                                 16'sd1,   16'sd1,   16'sd1,   16'sd1,   16'sd1,
                                 16'sd1,   16'sd0,   16'sd0,   16'sd0,   16'sd0}
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   learn_en,
  input  logic signed [stdp_pkg::WW-1:0]         wmax,
  input  logic signed [stdp_pkg::WW-1:0]         wmin,
  input  logic                                   tu_valid,
  input  logic [N_IN-1:0]                        pre_spk,
  input  logic [N_NEU-1:0]                       post_spk,
  input  logic                                   sample_last,
  output logic                                   busy,
  output logic                                   done,
  input  logic [$clog2(N_IN*N_NEU)-1:0]          rd_addr,
  output logic signed [stdp_pkg::WW-1:0]         rd_data
);
  localparam int N_SYN = N_IN * N_NEU;
  localparam int AddrW = $clog2(N_SYN);
  localparam int NW    = (N_NEU > 1) ? $clog2(N_NEU) : 1;
  localparam int IW    = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int AccW  = WW + 2;

  // control state
  logic                busy_q, busy_d, done_q, done_d;
  logic [AddrW-1:0]    sw_idx, sw_idx_d;
  logic [N_IN-1:0]     pre_q, pre_d;
  logic [N_NEU-1:0]    post_q, post_d;
  logic                last_q, last_d, learn_q, learn_d;
  logic [NW-1:0]       win_q, win_d, first_spk;

  wgt_t                wmem [N_SYN];

  age_t [N_IN-1:0]     pre_age;
  age_t [N_NEU-1:0]    post_age;
  logic [N_IN-1:0]     pre_seen;
  logic [N_NEU-1:0]    post_seen;

  logic                accept, sweep_end, wr_en, win_valid;
  logic [NW-1:0]       cur_neu;
  logic [IW-1:0]       cur_inp;
  logic                is_win, loser, silent;
  wgt_t                cur_w, delta, new_w;
  logic signed [AccW-1:0] sum, chg;

  assign accept    = tu_valid && !busy_q;
  assign sweep_end = busy_q && (sw_idx == AddrW'(N_SYN - 1));

  stdp_age #(.N(N_IN)) u_pre_age (
    .clk(clk), .rst_n(rst_n), .step(accept), .clear(sweep_end && last_q),
    .spk(pre_spk), .age(pre_age), .seen(pre_seen));

  stdp_age #(.N(N_NEU)) u_post_age (
    .clk(clk), .rst_n(rst_n), .step(accept), .clear(sweep_end && last_q),
    .spk(post_spk), .age(post_age), .seen(post_seen));

  // lowest-index spiking neuron
  always_comb begin
    first_spk = '0;
    for (int j = N_NEU - 1; j >= 0; j--)
      if (post_spk[j]) first_spk = NW'(j);
  end

  always_comb begin
    busy_d   = busy_q;
    done_d   = 1'b0;
    sw_idx_d = sw_idx;
    pre_d    = pre_q;
    post_d   = post_q;
    last_d   = last_q;
    learn_d  = learn_q;
    win_d    = win_q;
    if (accept) begin
      busy_d   = 1'b1;
      sw_idx_d = '0;
      pre_d    = pre_spk;
      post_d   = post_spk;
      last_d   = sample_last;
      learn_d  = learn_en;
      if (!(|post_seen) && (|post_spk)) win_d = first_spk;
    end else if (busy_q) begin
      if (sweep_end) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        sw_idx_d = sw_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sw_idx  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      last_q  <= 1'b0;
      learn_q <= 1'b0;
      win_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      sw_idx  <= sw_idx_d;
      pre_q   <= pre_d;
      post_q  <= post_d;
      last_q  <= last_d;
      learn_q <= learn_d;
      win_q   <= win_d;
    end
  end

  // per-synapse datapath
  assign cur_neu   = NW'(sw_idx / N_IN);
  assign cur_inp   = IW'(sw_idx % N_IN);
  assign win_valid = |post_seen;
  assign is_win    = win_valid && (cur_neu == win_q);
  assign loser     = win_valid && post_q[cur_neu] && !is_win;
  assign silent    = last_q && !pre_seen[cur_inp];
  assign cur_w     = wmem[sw_idx];

  stdp_delta #(
    .POS_TBL(POS_TBL), .NEG_TBL(NEG_TBL), .DMAX(DMAX),
    .LOSE_DEC(LOSE_DEC), .SILENT_DEC(SILENT_DEC)
  ) u_delta (
    .is_win(is_win), .pre_now(pre_q[cur_inp]), .post_now(post_q[cur_neu]),
    .loser(loser), .silent(silent), .pre_age(pre_age[cur_inp]),
    .post_age(post_age[win_q]), .delta(delta));

  always_comb begin
    sum = AccW'(cur_w) + AccW'(delta);
    if (sum > AccW'(wmax))      new_w = wmax;
    else if (sum < AccW'(wmin)) new_w = wmin;
    else                        new_w = wgt_t'(sum);
  end

  assign wr_en = busy_q && learn_q;
  assign chg   = AccW'(new_w) - AccW'(cur_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SYN; k++) wmem[k] <= wgt_t'(W_INIT);
    end else if (wr_en) begin
      wmem[sw_idx] <= new_w;
    end
  end

  assign rd_data = wmem[rd_addr];
  assign busy    = busy_q;
  assign done    = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q));
  // R9
  w_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wmin <= wmax) |-> (new_w <= wmax) && (new_w >= wmin));
  // R6
  step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (cur_w <= wmax) && (cur_w >= wmin) |->
      (chg <= AccW'(DMAX)) && (chg >= -AccW'(DMAX)));
  // R10
  learn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !learn_q |=> wmem[$past(sw_idx)] == $past(cur_w));
endmodule

// File: tb/stdp_updater_tb.sv
module stdp_updater_tb;
  localparam int NI = 8;
  localparam int NN = 4;
  localparam int NS = NI * NN;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              learn_en = 1'b0;
  logic signed [15:0] wmax = 16'sd1024;
  logic signed [15:0] wmin = -16'sd1024;
  logic              tu_valid = 1'b0;
  logic [NI-1:0]     pre_spk = '0;
  logic [NN-1:0]     post_spk = '0;
  logic              sample_last = 1'b0;
  logic              busy, done;
  logic [4:0]        rd_addr = '0;
  logic signed [15:0] rd_data;

  stdp_updater #(.N_IN(NI), .N_NEU(NN)) u_dut (
    .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .wmax(wmax), .wmin(wmin),
    .tu_valid(tu_valid), .pre_spk(pre_spk), .post_spk(post_spk),
    .sample_last(sample_last), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #2.5 clk = ~clk;   // 200 MHz

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct { int addr; int val; string tag; } exp_t;
  exp_t sb_q[$];

  int wm [NS];   // shadow weights
  int d  [NS];   // requested changes for the next time unit

  function automatic int pos_amt(int dt);
    return $rtoi(153.6 * $exp(-dt / 8.0) + 0.5);
  endfunction
  function automatic int neg_amt(int dt);
    return $rtoi(76.8 * $exp(-dt / 5.0) + 0.5);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver side: queue expected weights
  task automatic push_all(string tag);
    for (int a = 0; a < NS; a++) begin
      exp_t e;
      e.addr = a; e.val = wm[a]; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  // monitor side: pop and compare against the read port
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      rd_addr = 5'(e.addr);
      #1;
      check($signed(rd_data) == e.val, e.tag, int'($signed(rd_data)), e.val);
    end
  endtask

  task automatic commit(bit learn);
    for (int a = 0; a < NS; a++) begin
      if (learn) begin
        int dd, v;
        dd = d[a];
        if (dd > 16) dd = 16;
        if (dd < -16) dd = -16;
        v = wm[a] + dd;
        if (v > int'(wmax)) v = int'(wmax);
        else if (v < int'(wmin)) v = int'(wmin);
        wm[a] = v;
      end
      d[a] = 0;
    end
  endtask

  task automatic step(logic [NI-1:0] pre, logic [NN-1:0] post, bit last,
                      bit learn, bit inject);
    int cnt;
    bit seen_done;
    @(negedge clk);
    pre_spk = pre; post_spk = post; sample_last = last; learn_en = learn;
    tu_valid = 1'b1;
    @(negedge clk);
    tu_valid = 1'b0; pre_spk = '0; post_spk = '0; sample_last = 1'b0;
    cnt = 0;
    seen_done = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin seen_done = 1'b1; break; end
      if (busy) cnt++;
      if (inject && cnt == 5) begin
        tu_valid = 1'b1; pre_spk = '1; post_spk = 4'b0001; sample_last = 1'b1;
      end else begin
        tu_valid = 1'b0; pre_spk = '0; post_spk = '0; sample_last = 1'b0;
      end
      @(negedge clk);
    end
    tu_valid = 1'b0; pre_spk = '0; post_spk = '0; sample_last = 1'b0;
    check(seen_done && cnt == NS, "R2 busy length", cnt, NS);
    commit(learn);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NS; a++) begin wm[a] = 0; d[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    push_all("R1"); drain();

    // sample 1: input 0 spikes, winner 2 fires 20 units later with input 1
    step(8'h01, '0, 1'b0, 1'b1, 1'b0);
    idle(19);
    d[16] = pos_amt(20); d[17] = pos_amt(0);
    for (int i = 0; i < NI; i++) d[24+i] = -8;
    step(8'h02, 4'b1100, 1'b0, 1'b1, 1'b0);
    push_all("R3 R7 R6"); drain();

    // input 4 one unit after the winner: capped depression
    d[20] = -neg_amt(1);
    step(8'h10, '0, 1'b0, 1'b1, 1'b0);
    push_all("R4 R6"); drain();

    // input 5 ten units after the winner
    idle(8);
    d[21] = -neg_amt(10);
    step(8'h20, '0, 1'b0, 1'b1, 1'b0);
    push_all("R4"); drain();

    // input 6 thirty units after the winner: no change
    idle(19);
    step(8'h40, '0, 1'b0, 1'b1, 1'b0);
    push_all("R5"); drain();

    // winner fires again: input 5 at 21, input 6 at 1, others at 30+
    d[21] = pos_amt(21); d[22] = pos_amt(1);
    step('0, 4'b0100, 1'b0, 1'b1, 1'b0);
    push_all("R3 R5"); drain();

    // end of sample: inputs 2,3,7 never spiked
    for (int j = 0; j < NN; j++) begin
      d[j*NI+2] -= 4; d[j*NI+3] -= 4; d[j*NI+7] -= 4;
    end
    step('0, '0, 1'b1, 1'b1, 1'b0);
    push_all("R8"); drain();

    // sample 2 with learning off
    step(8'h01, 4'b0001, 1'b0, 1'b0, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    push_all("R10"); drain();

    // sample 3: tighter limits, new winner 1, injected pulse ignored
    wmax = 16'sd20; wmin = -16'sd10;
    d[15] = pos_amt(0);
    step(8'h80, 4'b0010, 1'b0, 1'b1, 1'b1);
    push_all("R2 R8 R9"); drain();

    // winner again (saturates at wmax), neuron 2 loses (floors at wmin)
    d[15] = pos_amt(0);
    for (int i = 0; i < NI; i++) d[16+i] = -8;
    step(8'h80, 4'b0110, 1'b0, 1'b1, 1'b0);
    push_all("R9 R7"); drain();

    // close sample 3: only input 7 spiked
    for (int j = 0; j < NN; j++)
      for (int i = 0; i < 7; i++) d[j*NI+i] -= 4;
    step('0, '0, 1'b1, 1'b1, 1'b0);
    push_all("R8"); drain();

    // sample 4: spike seen with learning off still times the next winner
    step(8'h08, '0, 1'b0, 1'b0, 1'b0);
    push_all("R10"); drain();
    d[3] = pos_amt(1);
    step('0, 4'b0001, 1'b0, 1'b1, 1'b0);
    push_all("R10 R3"); drain();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule